// File: doc/BRIEF.md
# Rolling-Shutter Row and Column Readout Sequencer

This block produces the digital timing that reads out a large active-pixel array one row at a time. For every row it reads, it first raises that row's select strobe. While the row is still selected it pulses the column sample-and-hold control. It then raises that row's reset strobe, unless resets are withheld. Next it walks the held column values out one pixel slot per clock cycle, with the row and column indices, toward an external converter. Every row period ends with a horizontal blanking interval. The select and reset strobes come out as one-hot vectors, one bit per row.

A frame is requested with a start pulse. The two mode inputs are captured only when that request is accepted. The non-destructive mode reads the rows exactly as the normal mode does but never issues a reset strobe, so charge keeps building between frames. The sparse mode reads only even rows and odd columns, which takes about a quarter of the full-frame time. Even in sparse mode, each skipped odd row gets its reset strobe during the blanking interval of the read row above it, so unread photodiodes cannot saturate and spill charge into their neighbours. Start-of-frame and start-of-line markers travel with the first pixel of the frame and of each line. A done pulse marks the last cycle of the frame.

Top module: `rs_readout_seq`

## Requirements
- R1: While reset is active, and after it is released until a start is accepted, `busy_o`, `pix_valid_o`, `sh_sample_o`, `frame_done_o`, `sof_o`, `sol_o` and every bit of `row_sel_o` and `row_rst_o` are 0. An asynchronous reset in the middle of a frame returns the block to idle at once.
- R2: `start_i` is accepted only while `busy_o` is 0, and `mode_ndr_i` and `mode_sparse_i` are captured in the same cycle. A start pulse or a mode change during a frame, including in the cycle of `frame_done_o`, does not change the running frame and starts no later frame.
- R3: Read rows are visited in ascending order. Each read row has its `row_sel_o` bit high for T_SET+T_SMP consecutive cycles, and `sh_sample_o` is high during the last T_SMP of those cycles. At most one `row_sel_o` bit is high at any time.
- R4: In normal mode (mode_ndr_i=0, mode_sparse_i=0), every row gets exactly T_RST reset cycles, after its sample pulse, and a row's select and reset strobes are never high together.
- R5: After a row's reset phase, `pix_valid_o` is high for one pixel per cycle, with `pix_row_o` holding the row and `pix_col_o` rising through the read columns. In normal mode a row delivers columns 0 to COLS-1.
- R6: With mode_ndr_i=1 captured, no bit of `row_sel_o`... no bit of `row_rst_o` is ever high. Selection, sampling, pixel order and frame length are the same as without it.
- R7: With mode_sparse_i=1 captured, only rows 0, 2, 4, ... (row index bit 0 = 0) are selected and read, and only columns 1, 3, 5, ... (column index bit 0 = 1) are delivered. ROWS and COLS are even.
- R8: In sparse mode without mode_ndr_i, every skipped row r+1 gets exactly T_RST reset cycles at the start of the blanking interval of read row r, and it is never selected.
- R9: `sol_o` is high for exactly the cycle of the first pixel of each read row. `sof_o` is high only together with the first pixel of read row 0.
- R10: `frame_done_o` is a single-cycle pulse in the last busy cycle of the frame. The frame lasts rows_read × (T_SET+T_SMP+T_RST+cols_read+HB) cycles, where HB = max(T_HBLK, T_RST).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Frame request, taken only when idle |
| mode_ndr_i | input | 1 | 1 = withhold all row resets (non-destructive) |
| mode_sparse_i | input | 1 | 1 = read even rows and odd columns only |
| row_sel_o | output | ROWS | One-hot row select strobes |
| row_rst_o | output | ROWS | One-hot row reset strobes |
| sh_sample_o | output | 1 | Column sample-and-hold capture pulse |
| pix_valid_o | output | 1 | A pixel slot is being delivered |
| pix_row_o | output | $clog2(ROWS) | Row index of the current pixel |
| pix_col_o | output | $clog2(COLS) | Column index of the current pixel |
| sol_o | output | 1 | First pixel of a line |
| sof_o | output | 1 | First pixel of the frame |
| frame_done_o | output | 1 | Last cycle of the frame |
| busy_o | output | 1 | Frame in progress |

## Verification
Two events can fall on the same clock edge: a fresh start request, and the last blanking cycle in which `frame_done_o` fires. The block is still busy in that cycle, so the request must be dropped. The bench provokes this by raising `start_i` in exactly the cycle where it sees the done pulse, with a mode change earlier in the same frame. It judges the result by the frame's length, pixel count and per-row reset tally, and by `busy_o` staying low afterwards. Per-row select and reset tallies and the expected pixel order are also checked in all four mode combinations.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_SAMPLE,
    PH_RESET,
    PH_SCAN,
    PH_HBLK
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rs_row_decoder.sv
module rs_row_decoder #(
  parameter int ROWS = 1024,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            sel_en,
  input  logic [RW-1:0]   sel_idx,
  input  logic            rst_en,
  input  logic [RW-1:0]   rst_idx,
  output logic [ROWS-1:0] row_sel,
  output logic [ROWS-1:0] row_rst
);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_sel[i] = sel_en && (sel_idx == RW'(i));
    assign row_rst[i] = rst_en && (rst_idx == RW'(i));
  end

endmodule

// File: rtl/rs_col_scan.sv
module rs_col_scan #(
  parameter int COLS = 512,
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          sparse,
  output logic [CW-1:0] col,
  output logic          first,
  output logic          last
);

  logic [CW-1:0] col_q, col_d;
  logic [CW-1:0] first_col;
  logic [CW-1:0] step;

  assign first_col = sparse ? CW'(1) : CW'(0);
  assign step      = sparse ? CW'(2) : CW'(1);

  always_comb begin
    col_d = col_q;
    if (load)
      col_d = first_col;
    else if (adv && (col_q != CW'(COLS - 1)))
      col_d = col_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col_q <= '0;
    else if (load || adv)
      col_q <= col_d;
  end

  assign col   = col_q;
  assign first = (col_q == first_col);
  assign last  = (col_q == CW'(COLS - 1));

endmodule

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
  import rs_seq_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int T_SET  = 4,
  parameter int T_SMP  = 2,
  parameter int T_RST  = 4,
  parameter int T_HBLK = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int HB   = imax(T_HBLK, T_RST),
  localparam int TMAX = imax(imax(T_SET, T_SMP), HB),
  localparam int CNTW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_ndr_i,
  input  logic          mode_sparse_i,
  input  logic          col_last,
  output phase_e        phase,
  output logic [RW-1:0] row,
  output logic          lat_ndr,
  output logic          lat_sparse,
  output logic          col_load,
  output logic          rst_en,
  output logic [RW-1:0] rst_idx,
  output logic          frame_done
);

  phase_e        ph_q, ph_d;
  logic [CW_T:0] unused_dummy;
  localparam int CW_T = 0;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [RW-1:0]   row_q, row_d;
  logic            ndr_q, ndr_d;
  logic            sp_q, sp_d;
  logic [CNTW-1:0] limit;
  logic            cnt_end;
  logic            last_row;
  logic [RW-1:0]   row_step;

  assign unused_dummy = '0;

  always_comb begin
    unique case (ph_q)
      PH_SETTLE: limit = CNTW'(T_SET);
      PH_SAMPLE: limit = CNTW'(T_SMP);
      PH_RESET:  limit = CNTW'(T_RST);
      PH_HBLK:   limit = CNTW'(HB);
      default:   limit = CNTW'(1);
    endcase
  end

  assign cnt_end  = (cnt_q == (limit - CNTW'(1)));
  assign last_row = sp_q ? (row_q == RW'(ROWS - 2)) : (row_q == RW'(ROWS - 1));
  assign row_step = sp_q ? RW'(2) : RW'(1);

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    row_d      = row_q;
    ndr_d      = ndr_q;
    sp_d       = sp_q;
    col_load   = 1'b0;
    frame_done = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = PH_SETTLE;
          cnt_d = '0;
          row_d = '0;
          ndr_d = mode_ndr_i;
          sp_d  = mode_sparse_i;
        end
      end
      PH_SETTLE: begin
        if (cnt_end) begin
          ph_d  = PH_SAMPLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      PH_SAMPLE: begin
        if (cnt_end) begin
          ph_d  = PH_RESET;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      PH_RESET: begin
        if (cnt_end) begin
          ph_d     = PH_SCAN;
          cnt_d    = '0;
          col_load = 1'b1;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      PH_SCAN: begin
        if (col_last) begin
          ph_d  = PH_HBLK;
          cnt_d = '0;
        end
      end
      PH_HBLK: begin
        if (cnt_end) begin
          cnt_d = '0;
          if (last_row) begin
            ph_d       = PH_IDLE;
            frame_done = 1'b1;
          end else begin
            ph_d  = PH_SETTLE;
            row_d = row_q + row_step;
          end
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      row_q <= '0;
      ndr_q <= 1'b0;
      sp_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
      ndr_q <= ndr_d;
      sp_q  <= sp_d;
    end
  end

  // Reset strobe: own row in the reset phase, the skipped row below in sparse blanking.
  assign rst_en  = !ndr_q &&
                   ((ph_q == PH_RESET) ||
                    ((ph_q == PH_HBLK) && sp_q && (cnt_q < CNTW'(T_RST))));
  assign rst_idx = (ph_q == PH_HBLK) ? (row_q + RW'(1)) : row_q;

  assign phase      = ph_q;
  assign row        = row_q;
  assign lat_ndr    = ndr_q;
  assign lat_sparse = sp_q;

endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
  import rs_seq_pkg::*;
#(
  parameter int COLS   = 512,
  parameter int ROWS   = 1024,
  parameter int T_SET  = 4,
  parameter int T_SMP  = 2,
  parameter int T_RST  = 4,
  parameter int T_HBLK = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            mode_ndr_i,
  input  logic            mode_sparse_i,
  output logic [ROWS-1:0] row_sel_o,
  output logic [ROWS-1:0] row_rst_o,
  output logic            sh_sample_o,
  output logic            pix_valid_o,
  output logic [RW-1:0]   pix_row_o,
  output logic [CW-1:0]   pix_col_o,
  output logic            sol_o,
  output logic            sof_o,
  output logic            frame_done_o,
  output logic            busy_o
);

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  phase_e        phase;
  logic [RW-1:0] row;
  logic          lat_ndr;
  logic          lat_sparse;
  logic          col_load;
  logic          rst_en;
  logic [RW-1:0] rst_idx;
  logic          frame_done;
  logic [CW-1:0] col;
  logic          col_first;
  logic          col_last;
  logic          scan_on;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rs_phase_ctrl #(
    .ROWS(ROWS), .T_SET(T_SET), .T_SMP(T_SMP), .T_RST(T_RST), .T_HBLK(T_HBLK)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_i       (start_i),
    .mode_ndr_i    (mode_ndr_i),
    .mode_sparse_i (mode_sparse_i),
    .col_last      (col_last),
    .phase         (phase),
    .row           (row),
    .lat_ndr       (lat_ndr),
    .lat_sparse    (lat_sparse),
    .col_load      (col_load),
    .rst_en        (rst_en),
    .rst_idx       (rst_idx),
    .frame_done    (frame_done)
  );

  assign scan_on = (phase == PH_SCAN);

  rs_col_scan #(.COLS(COLS)) u_cols (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (col_load),
    .adv    (scan_on),
    .sparse (lat_sparse),
    .col    (col),
    .first  (col_first),
    .last   (col_last)
  );

  rs_row_decoder #(.ROWS(ROWS)) u_rows (
    .sel_en  ((phase == PH_SETTLE) || (phase == PH_SAMPLE)),
    .sel_idx (row),
    .rst_en  (rst_en),
    .rst_idx (rst_idx),
    .row_sel (row_sel_o),
    .row_rst (row_rst_o)
  );

  assign sh_sample_o  = (phase == PH_SAMPLE);
  assign pix_valid_o  = scan_on;
  assign pix_row_o    = row;
  assign pix_col_o    = col;
  assign sol_o        = scan_on && col_first;
  assign sof_o        = scan_on && col_first && (row == '0);
  assign frame_done_o = frame_done;
  assign busy_o       = (phase != PH_IDLE);

endmodule

// File: rtl/rs_readout_seq_chk.sv
module rs_readout_seq_chk #(
  parameter int ROWS = 1024,
  parameter int COLS = 512,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [ROWS-1:0] row_sel_o,
  input logic [ROWS-1:0] row_rst_o,
  input logic            pix_valid_o,
  input logic [RW-1:0]   pix_row_o,
  input logic [CW-1:0]   pix_col_o,
  input logic            sol_o,
  input logic            sof_o,
  input logic            frame_done_o,
  input logic            busy_o,
  input logic            lat_ndr,
  input logic            lat_sparse
);

  // R3
  a_r3_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel_o));

  // R4
  a_r4_sel_rst_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel_o & row_rst_o) == '0);

  // R6
  a_r6_ndr_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && lat_ndr) |-> (row_rst_o == '0));

  // R2
  a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r2_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !frame_done_o) |=> busy_o);

  // R5
  a_r5_col_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && $past(pix_valid_o)) |-> (pix_col_o > $past(pix_col_o)));

  // R7
  a_r7_sparse_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && lat_sparse) |-> (pix_col_o[0] && !pix_row_o[0]));

  // R9
  a_r9_sof_with_sol: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (sol_o && pix_valid_o && (pix_row_o == '0)));

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (!frame_done_o && !busy_o));

endmodule

bind rs_readout_seq rs_readout_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_i      (start_i),
  .row_sel_o    (row_sel_o),
  .row_rst_o    (row_rst_o),
  .pix_valid_o  (pix_valid_o),
  .pix_row_o    (pix_row_o),
  .pix_col_o    (pix_col_o),
  .sol_o        (sol_o),
  .sof_o        (sof_o),
  .frame_done_o (frame_done_o),
  .busy_o       (busy_o),
  .lat_ndr      (lat_ndr),
  .lat_sparse   (lat_sparse)
);

// File: tb/tb_rs_readout_seq.sv
module tb_rs_readout_seq;

  localparam int CLK_PERIOD = 10;
  localparam int COLS   = 8;
  localparam int ROWS   = 6;
  localparam int T_SET  = 2;
  localparam int T_SMP  = 1;
  localparam int T_RST  = 2;
  localparam int T_HBLK = 3;
  localparam int HB     = (T_HBLK > T_RST) ? T_HBLK : T_RST;
  localparam int RW     = $clog2(ROWS);
  localparam int CW     = $clog2(COLS);

  // {ndr, sparse, expected pixel count}
  localparam logic [17:0] VEC [4] = '{
    {1'b0, 1'b0, 16'd48},
    {1'b0, 1'b1, 16'd12},
    {1'b1, 1'b0, 16'd48},
    {1'b1, 1'b1, 16'd12}
  };

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic            mode_ndr_i;
  logic            mode_sparse_i;
  logic [ROWS-1:0] row_sel_o;
  logic [ROWS-1:0] row_rst_o;
  logic            sh_sample_o;
  logic            pix_valid_o;
  logic [RW-1:0]   pix_row_o;
  logic [CW-1:0]   pix_col_o;
  logic            sol_o;
  logic            sof_o;
  logic            frame_done_o;
  logic            busy_o;

  rs_readout_seq #(
    .COLS(COLS), .ROWS(ROWS), .T_SET(T_SET), .T_SMP(T_SMP),
    .T_RST(T_RST), .T_HBLK(T_HBLK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_ndr_i(mode_ndr_i),
    .mode_sparse_i(mode_sparse_i), .row_sel_o(row_sel_o), .row_rst_o(row_rst_o),
    .sh_sample_o(sh_sample_o), .pix_valid_o(pix_valid_o), .pix_row_o(pix_row_o),
    .pix_col_o(pix_col_o), .sol_o(sol_o), .sof_o(sof_o),
    .frame_done_o(frame_done_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests;
  int n_fail;

  // monitor state
  bit mon_en;
  bit exp_sp;
  int exp_r, exp_c;
  int cyc, pix_cnt, ord_err, mk_err, ovl, smp, done_cnt;
  int sel_cnt [ROWS];
  int rst_cnt [ROWS];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (busy_o) cyc++;
      if (frame_done_o) done_cnt++;
      if (sh_sample_o) smp++;
      if ((row_sel_o & row_rst_o) != '0) ovl++;
      if ($countones(row_sel_o) > 1) ovl++;
      for (int i = 0; i < ROWS; i++) begin
        if (row_sel_o[i]) sel_cnt[i]++;
        if (row_rst_o[i]) rst_cnt[i]++;
      end
      if (pix_valid_o) begin
        pix_cnt++;
        if (int'(pix_row_o) != exp_r || int'(pix_col_o) != exp_c) ord_err++;
        if (sol_o != (exp_c == (exp_sp ? 1 : 0))) mk_err++;
        if (sof_o != (exp_c == (exp_sp ? 1 : 0) && exp_r == 0)) mk_err++;
        if (exp_c >= COLS - 1) begin
          exp_c = exp_sp ? 1 : 0;
          exp_r = exp_r + (exp_sp ? 2 : 1);
        end else begin
          exp_c = exp_c + (exp_sp ? 2 : 1);
        end
      end else if (sol_o || sof_o) begin
        mk_err++;
      end
    end
  end

  task automatic clear_mon(input bit sp);
    cyc = 0; pix_cnt = 0; ord_err = 0; mk_err = 0; ovl = 0; smp = 0; done_cnt = 0;
    for (int i = 0; i < ROWS; i++) begin
      sel_cnt[i] = 0;
      rst_cnt[i] = 0;
    end
    exp_sp = sp;
    exp_r  = 0;
    exp_c  = sp ? 1 : 0;
  endtask

  // disturb: flip modes and pulse start mid-frame, and again in the done cycle
  task automatic run_frame(input bit ndr, input bit sp, input bit disturb);
    int  n;
    bit  seen;
    clear_mon(sp);
    @(negedge clk);
    mode_ndr_i = ndr; mode_sparse_i = sp; start_i = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0; seen = 1'b0;
    while (!seen && n < 5000) begin
      if (disturb && n == 30) begin
        start_i = 1'b1; mode_ndr_i = !ndr; mode_sparse_i = !sp;
      end else if (disturb && n == 31) begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
      if (frame_done_o) begin
        seen = 1'b1;
        if (disturb) start_i = 1'b1;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    chk(seen, "R10", "watchdog frame end", int'(seen), 1);
  endtask

  task automatic verify(input bit ndr, input bit sp, input int exp_pix);
    int rows_rd, cols_rd, period, sel_bad, rst_bad, e_sel, e_rst;
    rows_rd = sp ? ROWS / 2 : ROWS;
    cols_rd = sp ? COLS / 2 : COLS;
    period  = T_SET + T_SMP + T_RST + cols_rd + HB;
    sel_bad = 0; rst_bad = 0;
    for (int i = 0; i < ROWS; i++) begin
      e_sel = (sp && (i % 2 == 1)) ? 0 : T_SET + T_SMP;
      e_rst = ndr ? 0 : T_RST;
      if (sel_cnt[i] != e_sel) sel_bad++;
      if (rst_cnt[i] != e_rst) rst_bad++;
    end
    chk(pix_cnt == exp_pix, sp ? "R7" : "R5", "pixel count", pix_cnt, exp_pix);
    chk(ord_err == 0, sp ? "R7" : "R5", "pixel order errors", ord_err, 0);
    chk(mk_err == 0, "R9", "line/frame marker errors", mk_err, 0);
    chk(cyc == rows_rd * period, "R10", "frame cycles", cyc, rows_rd * period);
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(ovl == 0, "R3", "select overlap", ovl, 0);
    chk(smp == rows_rd * T_SMP, "R3", "sample cycles", smp, rows_rd * T_SMP);
    chk(sel_bad == 0, sp ? "R7" : "R3", "rows with wrong select time", sel_bad, 0);
    if (ndr)
      chk(rst_bad == 0, "R6", "rows with reset under ndr", rst_bad, 0);
    else if (sp)
      chk(rst_bad == 0, "R8", "rows with wrong reset in sparse", rst_bad, 0);
    else
      chk(rst_bad == 0, "R4", "rows with wrong reset time", rst_bad, 0);
    chk(busy_o == 1'b0, "R2", "busy after frame", int'(busy_o), 0);
  endtask

  task automatic idle_outputs(input string what);
    chk(!busy_o && !pix_valid_o && !sh_sample_o && !frame_done_o && !sol_o && !sof_o,
        "R1", what, int'({busy_o, pix_valid_o, sh_sample_o, frame_done_o}), 0);
    chk(row_sel_o == '0 && row_rst_o == '0, "R1", {what, " strobes"},
        int'(row_sel_o | row_rst_o), 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; mon_en = 1'b0;
    start_i = 1'b0; mode_ndr_i = 1'b0; mode_sparse_i = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    idle_outputs("outputs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_outputs("outputs idle after reset");

    // table walk over the four mode combinations
    for (int k = 0; k < 4; k++) begin
      run_frame(VEC[k][17], VEC[k][16], 1'b0);
      verify(VEC[k][17], VEC[k][16], int'(VEC[k][15:0]));
    end

    // R2: mode change and start mid-frame, start in the done cycle
    run_frame(1'b0, 1'b0, 1'b1);
    verify(1'b0, 1'b0, 48);
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b0, "R2", "no frame from stray start", int'(busy_o), 0);

    // R1: asynchronous reset in the middle of a frame
    @(negedge clk);
    mode_ndr_i = 1'b0; mode_sparse_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b1, "R1", "busy before mid-frame reset", int'(busy_o), 1);
    #2 rst_n = 1'b0;
    @(negedge clk);
    idle_outputs("outputs after mid-frame reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_frame(1'b0, 1'b0, 1'b0);
    chk(pix_cnt == 48, "R1", "full frame after recovery", pix_cnt, 48);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R10 global watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule